// File: doc/BRIEF.md
# Integrating Light-Sensor Conversion Sequencer

This block is the digital control core of an integrating light-to-digital converter. The analog front end is modelled as two pulse inputs, one per photodiode. Each pulse stands for one quantum of collected charge, and the block counts them over an integration window. A narrow byte-wide register port configures the block. Through it a host sets the enable and power-down state, the timing source, the channel selection, the conversion width, two interrupt thresholds and a gain/range code, and reads the latest result back.

The integration window can be timed in two ways. The block can count a fixed number of clock cycles, chosen by the width code. It can also run between host sync strobes. In the differential mode the block runs a diode-1 pass and then a diode-2 pass of the same length, and reports the clamped signed difference. After each finished conversion the result is latched, a one-cycle done pulse is raised, and an interrupt flag is set if the result lies outside the threshold band.

Top module: `ls_conv_seq`

## Requirements
- R1: After reset the command register is 0x00, control reads 0x00, the low threshold is 0x0000, the high threshold is 0xFFFF, the result is 0 and irq_o is 0. The byte address map is: 0 command, 1 control, 2/3 low threshold (low byte first), 4/5 high threshold, 6/7 result (read only), 8 sync strobe, 9 flag-clear strobe. Command bit 4 always reads 0.
- R2: Conversions run only while command bit 7 (enable) is 1, bit 6 (power-down) is 0 and the channel code is not 11. Otherwise no done pulse occurs and the last result is kept.
- R3: In internal timing (command bit 5 = 0), width code bits 1:0 give windows of 00: 65536, 01: 4096, 10: 256 and 11: 16 clock cycles. Conversions repeat back to back.
- R4: In external timing (command bit 5 = 1), the first write of 1 to address 8 after enabling starts integration. Each later such write ends the window, including the cycle it is presented in, and starts the next window.
- R5: In internal timing a sync strobe has no effect on the window or the result.
- R6: Channel code bits 3:2 = 00 counts diode 1 only and 01 counts diode 2 only.
- R7: Single-diode counts saturate at 2^n-1, where n is 16, 12, 8 or 4 for width codes 00, 01, 10 and 11.
- R8: Channel code 10 runs a diode-1 window, then a diode-2 window, and reports diode1 minus diode2. The difference is clamped to plus or minus (2^(n-1)-1) and sign-extended to 16 bits. One result is produced per pair of windows.
- R9: Any write to the command register restarts the window counter, the pass sequence and the accumulators.
- R10: After each conversion the flag (control bit 5, irq_o) is set if the result is below the low threshold or above the high threshold. The comparison is signed in differential mode and unsigned otherwise.
- R11: The flag stays set until control is written with bit 5 = 0, or address 9 is written with bit 0 = 1. A new crossing in the same cycle wins over a clear.
- R12: Control bits 3:2 store a gain/range code that reads back unchanged.
- R13: result_o updates and done_o pulses for one cycle at the clock edge that follows the last integrating cycle. In internal timing, done_o rises 16 edges after a 16-cycle window is started by a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 8 | Read data (combinational) |
| diode1_pulse | input | 1 | Charge-quantum pulse from diode 1 |
| diode2_pulse | input | 1 | Charge-quantum pulse from diode 2 |
| result_o | output | 16 | Latest conversion result |
| done_o | output | 1 | One-cycle pulse when result_o updates |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions assume that a change of timing, channel or width arrives only through a command write, so every such change coincides with a restart. They also assume the pulse inputs carry at most one charge quantum per cycle. The stimulus obeys both. It writes the command register whenever it alters a setting and drives the diode pulses as single-cycle divided strobes from a free-running counter. Because of this, the expected counts follow directly from the window length divided by the pulse period, whatever the phase of the pulses.

// File: rtl/ls_pkg.sv
package ls_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int RES_W  = 16;

  localparam int ADR_CMD  = 0;
  localparam int ADR_CTRL = 1;
  localparam int ADR_TLO  = 2;
  localparam int ADR_SYNC = 8;
  localparam int ADR_CLR  = 9;

  typedef enum logic [1:0] {
    CH_D1   = 2'b00,
    CH_D2   = 2'b01,
    CH_DIFF = 2'b10,
    CH_NOP  = 2'b11
  } chan_e;

  typedef struct packed {
    logic       en;
    logic       pd;
    logic       ext;
    logic       rsv;
    chan_e      chan;
    logic [1:0] wcode;
  } cmd_t;

  function automatic int unsigned width_bits(input logic [1:0] c);
    case (c)
      2'b00:   return 16;
      2'b01:   return 12;
      2'b10:   return 8;
      default: return 4;
    endcase
  endfunction

  // 2^n - 1: both the saturation ceiling and the last counter value of a window
  function automatic logic [RES_W-1:0] count_max(input logic [1:0] c);
    logic [RES_W:0] full;
    full = ({{RES_W{1'b0}}, 1'b1} << width_bits(c)) - 1'b1;
    return full[RES_W-1:0];
  endfunction

  function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] acc,
                                               input logic pulse,
                                               input logic [1:0] c);
    if (pulse && (acc < count_max(c))) return acc + 1'b1;
    return acc;
  endfunction

  function automatic logic [RES_W-1:0] diff_clamp(input logic [RES_W-1:0] a,
                                                  input logic [RES_W-1:0] b,
                                                  input logic [1:0] c);
    logic signed [RES_W+1:0] d;
    logic signed [RES_W+1:0] lim;
    d   = $signed({2'b00, a}) - $signed({2'b00, b});
    lim = $signed({2'b00, count_max(c)} >> 1);
    if (d > lim) d = lim;
    else if (d < -lim) d = -lim;
    return d[RES_W-1:0];
  endfunction

  function automatic logic out_of_band(input logic [RES_W-1:0] v,
                                       input logic [RES_W-1:0] lo,
                                       input logic [RES_W-1:0] hi,
                                       input logic sgn);
    if (sgn) return ($signed(v) < $signed(lo)) || ($signed(v) > $signed(hi));
    return (v < lo) || (v > hi);
  endfunction
endpackage

// File: rtl/ls_regs.sv
module ls_regs
  import ls_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int TW = RES_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output cmd_t          cmd,
  output logic [1:0]    gain,
  output logic [TW-1:0] thr_lo,
  output logic [TW-1:0] thr_hi,
  output logic          cmd_wr,
  output logic          sync_stb,
  output logic          clr_stb
);
  localparam int NB      = TW / DW;
  localparam int ADR_THI = ADR_TLO + NB;

  assign cmd_wr   = wr_en && (wr_addr == AW'(ADR_CMD));
  assign sync_stb = wr_en && (wr_addr == AW'(ADR_SYNC)) && wr_data[0];
  assign clr_stb  = wr_en && (((wr_addr == AW'(ADR_CTRL)) && !wr_data[5]) ||
                              ((wr_addr == AW'(ADR_CLR)) && wr_data[0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd    <= '0;
      gain   <= '0;
      thr_lo <= '0;
      thr_hi <= '1;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_CMD))
        cmd <= cmd_t'({wr_data[7:5], 1'b0, wr_data[3:0]});
      if (wr_addr == AW'(ADR_CTRL))
        gain <= wr_data[3:2];
      for (int k = 0; k < NB; k++) begin
        if (wr_addr == AW'(ADR_TLO + k)) thr_lo[k*DW +: DW] <= wr_data;
        if (wr_addr == AW'(ADR_THI + k)) thr_hi[k*DW +: DW] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/ls_window.sv
module ls_window
  import ls_pkg::*;
#(
  parameter int CW = RES_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       ext_mode,
  input  logic       diff_mode,
  input  logic [1:0] wcode,
  input  logic       sync_stb,
  output logic       integrating,
  output logic       pass_end,
  output logic       phase,
  output logic       conv_done
);
  logic [CW-1:0] cnt;
  logic          started;
  logic          live;

  assign live        = run && !restart;
  assign integrating = live && (ext_mode ? started : 1'b1);
  assign pass_end    = integrating &&
                       (ext_mode ? sync_stb : (cnt == CW'(count_max(wcode))));
  assign conv_done   = pass_end && (!diff_mode || phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase   <= 1'b0;
      started <= 1'b0;
    end else if (!live) begin
      cnt     <= '0;
      phase   <= 1'b0;
      started <= 1'b0;
    end else begin
      if (ext_mode && sync_stb) started <= 1'b1;
      if (pass_end) begin
        cnt   <= '0;
        phase <= diff_mode ? !phase : 1'b0;
      end else if (integrating && !ext_mode) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  pass_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |-> run);
  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> $past(ext_mode && sync_stb));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && integrating && !pass_end) |=> (cnt == CW'($past(cnt) + 1'b1)));
  // R8
  phase_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> diff_mode);
endmodule

// File: rtl/ls_accum.sv
module ls_accum
  import ls_pkg::*;
#(
  parameter int W = RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         integrating,
  input  logic         pass_end,
  input  logic         phase,
  input  chan_e        chan,
  input  logic [1:0]   wcode,
  input  logic         d1,
  input  logic         d2,
  output logic [W-1:0] conv_val
);
  logic [W-1:0] acc;
  logic [W-1:0] first;
  logic [W-1:0] acc_sum;
  logic         take_d2;
  logic         pulse;

  assign take_d2  = (chan == CH_D2) || ((chan == CH_DIFF) && phase);
  assign pulse    = take_d2 ? d2 : d1;
  assign acc_sum  = sat_inc(acc, pulse, wcode);
  assign conv_val = (chan == CH_DIFF) ? diff_clamp(first, acc_sum, wcode) : acc_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      first <= '0;
    end else if (!integrating) begin
      acc   <= '0;
      first <= '0;
    end else if (pass_end) begin
      acc <= '0;
      if ((chan == CH_DIFF) && !phase) first <= acc_sum;
    end else begin
      acc <= acc_sum;
    end
  end

  // R7
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= count_max(wcode));
endmodule

// File: rtl/ls_conv_seq.sv
module ls_conv_seq
  import ls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              diode1_pulse,
  input  logic              diode2_pulse,
  output logic [RES_W-1:0]  result_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int NB      = RES_W / DATA_W;
  localparam int ADR_THI = ADR_TLO + NB;
  localparam int ADR_RES = ADR_THI + NB;

  cmd_t             cmd;
  logic [1:0]       gain;
  logic [RES_W-1:0] thr_lo, thr_hi;
  logic             cmd_wr, sync_stb, clr_stb;
  logic             run, integrating, pass_end, phase, conv_done;
  logic [RES_W-1:0] conv_val;
  logic             set_req;
  logic             flag;

  ls_regs #(.AW(ADDR_W), .DW(DATA_W), .TW(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd(cmd), .gain(gain), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .cmd_wr(cmd_wr), .sync_stb(sync_stb), .clr_stb(clr_stb)
  );

  assign run = cmd.en && !cmd.pd && (cmd.chan != CH_NOP);

  ls_window #(.CW(RES_W)) u_win (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cmd_wr), .ext_mode(cmd.ext),
    .diff_mode(cmd.chan == CH_DIFF), .wcode(cmd.wcode), .sync_stb(sync_stb),
    .integrating(integrating), .pass_end(pass_end), .phase(phase), .conv_done(conv_done)
  );

  ls_accum #(.W(RES_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .integrating(integrating), .pass_end(pass_end),
    .phase(phase), .chan(cmd.chan), .wcode(cmd.wcode),
    .d1(diode1_pulse), .d2(diode2_pulse), .conv_val(conv_val)
  );

  assign set_req = conv_done && out_of_band(conv_val, thr_lo, thr_hi, cmd.chan == CH_DIFF);
  assign irq_o   = flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      done_o   <= 1'b0;
      flag     <= 1'b0;
    end else begin
      done_o <= conv_done;
      if (conv_done) result_o <= conv_val;
      if (set_req) flag <= 1'b1;
      else if (clr_stb) flag <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADR_CMD)) rd_data = cmd;
    if (rd_addr == ADDR_W'(ADR_CTRL)) rd_data = {2'b00, flag, 1'b0, gain, 2'b00};
    for (int k = 0; k < NB; k++) begin
      if (rd_addr == ADDR_W'(ADR_TLO + k)) rd_data = thr_lo[k*DATA_W +: DATA_W];
      if (rd_addr == ADDR_W'(ADR_THI + k)) rd_data = thr_hi[k*DATA_W +: DATA_W];
      if (rd_addr == ADDR_W'(ADR_RES + k)) rd_data = result_o[k*DATA_W +: DATA_W];
    end
  end

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_req) |=> !irq_o);
  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> done_o);
  // R13
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done_o);
endmodule

// File: tb/tb_ls_conv_seq.sv
module tb_ls_conv_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        d1 = 1'b0, d2 = 1'b0;
  logic [15:0] result_o;
  logic        done_o, irq_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, d1_div = 0, d2_div = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = !clk;

  ls_conv_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .diode1_pulse(d1), .diode2_pulse(d2),
    .result_o(result_o), .done_o(done_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // divided pulse generators, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    d1 <= (d1_div != 0) && ((cyc % d1_div) == 0);
    d2 <= (d2_div != 0) && ((cyc % d2_div) == 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2: actual unexpected done %h expected none", result_o);
      end else begin
        chk(tag_q.pop_front(), result_o, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, {8'h00, rd_data}, {8'h00, exp});
  endtask

  task automatic push(input int n, input logic [15:0] v, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(req);
    end
  endtask

  task automatic drain_and_stop();
    while (exp_q.size() != 0) @(negedge clk);
    wr(4'h0, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_conv(input logic [7:0] c, input int n, input logic [15:0] v,
                          input string req);
    push(n, v, req);
    wr(4'h0, c);
    drain_and_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(4'h0, 8'h00, "R1");
    rd_chk(4'h1, 8'h00, "R1");
    rd_chk(4'h2, 8'h00, "R1");
    rd_chk(4'h4, 8'hFF, "R1");
    rd_chk(4'h5, 8'hFF, "R1");
    chk("R1", result_o, 16'h0000);
    chk("R1", {15'd0, irq_o}, 16'h0000);

    // R12 gain readback, R1 reserved command bit
    wr(4'h1, 8'h08);
    rd_chk(4'h1, 8'h08, "R12");
    wr(4'h0, 8'h1F);
    rd_chk(4'h0, 8'h0F, "R1");
    wr(4'h0, 8'h00);

    // thresholds: low 5, high 10
    wr(4'h2, 8'h05); wr(4'h3, 8'h00); wr(4'h4, 8'h0A); wr(4'h5, 8'h00);

    // R6 diode 1, R3 16-cycle window
    d1_div = 2; d2_div = 1;
    run_conv(8'h83, 3, 16'd8, "R6");
    chk("R10", {15'd0, irq_o}, 16'h0000);

    // R6 diode 2
    d1_div = 1; d2_div = 2;
    run_conv(8'h87, 2, 16'd8, "R6");

    // R7 saturation at 15
    d1_div = 1; d2_div = 0;
    run_conv(8'h83, 2, 16'd15, "R7");
    chk("R10", {15'd0, irq_o}, 16'h0001);
    wr(4'h1, 8'h08);
    chk("R11", {15'd0, irq_o}, 16'h0000);
    rd_chk(4'h1, 8'h08, "R12");

    // R10 below low threshold, R11 clear strobe
    d1_div = 4;
    run_conv(8'h83, 1, 16'd4, "R10");
    chk("R10", {15'd0, irq_o}, 16'h0001);
    wr(4'h9, 8'h01);
    chk("R11", {15'd0, irq_o}, 16'h0000);

    // R3 256- and 4096-cycle windows
    d1_div = 1;
    run_conv(8'h82, 1, 16'd255, "R7");
    d1_div = 2;
    run_conv(8'h81, 1, 16'd2048, "R3");
    wr(4'h9, 8'h01);

    // R8 differential
    d1_div = 2; d2_div = 4;
    run_conv(8'h8B, 2, 16'd4, "R8");
    wr(4'h9, 8'h01);
    wr(4'h2, 8'hF0); wr(4'h3, 8'hFF); wr(4'h4, 8'h05); wr(4'h5, 8'h00);
    d1_div = 0; d2_div = 1;
    run_conv(8'h8B, 1, 16'hFFF9, "R8");
    chk("R10", {15'd0, irq_o}, 16'h0000);
    d1_div = 1; d2_div = 0;
    run_conv(8'h8B, 1, 16'h0007, "R8");
    chk("R10", {15'd0, irq_o}, 16'h0001);
    wr(4'h9, 8'h01);
    wr(4'h2, 8'h05); wr(4'h3, 8'h00); wr(4'h4, 8'h0A); wr(4'h5, 8'h00);

    // R5 sync ignored in internal timing
    d1_div = 2; d2_div = 0;
    push(2, 16'd8, "R5");
    wr(4'h0, 8'h83);
    repeat (5) @(negedge clk);
    wr(4'h8, 8'h01);
    drain_and_stop();

    // R9 restart on command write, R13 latency
    push(1, 16'd8, "R9");
    wr(4'h0, 8'h82);
    repeat (10) @(negedge clk);
    wr(4'h0, 8'h83);
    lat = 0;
    while (!done_o) begin
      @(negedge clk);
      lat++;
    end
    chk("R13", 16'(lat), 16'd16);
    drain_and_stop();

    // R4 external timing: idle before first sync, windows between syncs
    d1_div = 1;
    wr(4'h0, 8'hA0);
    repeat (30) @(negedge clk);
    push(1, 16'd42, "R4");
    push(1, 16'd22, "R4");
    wr(4'h8, 8'h01);
    repeat (40) @(negedge clk);
    wr(4'h8, 8'h01);
    repeat (20) @(negedge clk);
    wr(4'h8, 8'h01);
    drain_and_stop();
    wr(4'h9, 8'h01);

    // R2 power-down and no-operation channel keep the result
    wr(4'h0, 8'hC3);
    repeat (100) @(negedge clk);
    wr(4'h0, 8'h8F);
    repeat (60) @(negedge clk);
    wr(4'h0, 8'h00);
    rd_chk(4'h6, 8'h16, "R2");
    rd_chk(4'h7, 8'h00, "R2");
    chk("R2", {15'd0, irq_o}, 16'h0000);

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R13: actual %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule